// File: doc/BRIEF.md
# Fixed-Priority Shared-Medium Arbiter

This block sits between several bus initiators and several targets that share one transfer medium. Signalling uses three events. An initiator pulses a request together with a target index. The chosen target answers with an acknowledge pulse, which marks the start of the transfer. Later the target pulses done, which marks the end. The arbiter lets exactly one transaction use the medium at a time. It is reserved from the moment a request is forwarded, and it stays occupied until that transaction's done.

When two initiators ask in the same cycle, the lower-numbered initiator wins. The loser's request is kept in a per-initiator pending bit, together with the target index it gave. That pending request is forwarded in the first cycle in which the medium is free and no higher-priority request competes, including a fresh one arriving in that same cycle. The request seen by the targets in any cycle is either a fresh, conflict-free request or a reissued pending one, and never both. Acknowledge and done from the addressed target are steered back to the initiator that owns the medium. Initiator 0 has the highest priority. There may be at most 32 initiators, and every target index must be below the number of targets.

Top module: `arb_shared_medium`

## Requirements
- R1: While reset is low and in the first cycle after it, `s_req`, `m_ack` and `m_done` are all zero, and no request is pending.
- R2: A request from one initiator on an idle medium, with nothing pending, is forwarded in the same cycle as a one-cycle pulse on `s_req[k]`, where k is the target index given in `m_sel` (bits i*SW up to i*SW+SW-1 for initiator i).
- R3: When several initiators request in the same idle cycle, only the lowest-numbered one is forwarded; each of the others becomes pending.
- R4: A pending request is forwarded, to the target index captured when it was made, in the first cycle in which the medium is idle and no lower-numbered initiator has a pending or fresh request.
- R5: After a request is forwarded, no further bit of `s_req` rises until the cycle after the done of that transaction.
- R6: Within a transaction, `s_ack` from the addressed target raises `m_ack` of the owning initiator in the same cycle. `s_ack` from any other target, or outside the acknowledge phase, leaves `m_ack` at zero.
- R7: After acknowledge, `s_done` from the addressed target raises `m_done` of the owner in the same cycle, and the medium is idle from the next cycle. `s_done` from any other target leaves `m_done` at zero.
- R8: A new request from an initiator that already has a pending request, or that owns the medium, is dropped. It changes neither the stored target index nor the later sequence of forwarded requests.
- R9: At most one bit of `s_req`, of `m_ack` and of `m_done` is high in any cycle. Every forwarded request matches, in order, a request that was accepted.
- R10: A reissued pending request never occurs in the same cycle as a forwarded request of any other initiator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | N | Request pulse per initiator |
| m_sel | input | N*SW | Target index per initiator, SW = max(1, ceil(log2 M)) |
| m_ack | output | N | Acknowledge pulse steered to the owner |
| m_done | output | N | Done pulse steered to the owner |
| s_req | output | M | Forwarded request pulse per target |
| s_ack | input | M | Acknowledge pulse from each target |
| s_done | input | M | Done pulse from each target |

## Verification
A corrupted pending bit shows up in the first idle cycle. Either a request pulse appears that no initiator made, or an expected reissue is missing. A wrong stored target index lights the wrong `s_req` bit on reissue, which is visible in the cycle the reissue happens. A stale owner or phase register either steers `m_ack` and `m_done` to the wrong initiator in the same cycle as the target pulse, or blocks or admits the next request one cycle later. The bench therefore compares the whole ordered stream of forwarded requests against its own model, and checks every steered response in the cycle it occurs.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Phase of the single shared medium.
  typedef enum logic [1:0] {
    MED_IDLE = 2'd0,
    MED_WAIT = 2'd1,
    MED_XFER = 2'd2
  } med_phase_t;

  // Isolates the lowest set bit: the static-priority pick, index 0 first.
  function automatic logic [31:0] lowest_set(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/arb_pending.sv
module arb_pending #(
  parameter int N  = 2,
  parameter int SW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    accept,
  input  logic [N-1:0]    grant,
  input  logic [N*SW-1:0] sel_in,
  output logic [N-1:0]    pend,
  output logic [N*SW-1:0] pend_sel
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i]               <= 1'b0;
        pend_sel[i*SW +: SW]  <= '0;
      end else if (grant[i]) begin
        pend[i]               <= 1'b0;
      end else if (accept[i]) begin
        pend[i]               <= 1'b1;
        pend_sel[i*SW +: SW]  <= sel_in[i*SW +: SW];
      end
    end
  end

endmodule

// File: rtl/arb_medium_ctl.sv
module arb_medium_ctl
  import arb_pkg::*;
#(
  parameter int N  = 2,
  parameter int M  = 2,
  parameter int SW = 1,
  parameter int MW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_any,
  input  logic [MW-1:0] grant_idx,
  input  logic [SW-1:0] grant_sel,
  input  logic [M-1:0]  s_ack,
  input  logic [M-1:0]  s_done,
  output logic          idle,
  output logic [MW-1:0] owner,
  output logic [N-1:0]  ack_out,
  output logic [N-1:0]  done_out
);

  med_phase_t    phase;
  logic [SW-1:0] target;
  logic          ack_hit;
  logic          done_hit;

  assign idle     = (phase == MED_IDLE);
  assign ack_hit  = (phase == MED_WAIT) && s_ack[target];
  assign done_hit = (phase == MED_XFER) && s_done[target];

  for (genvar i = 0; i < N; i++) begin : g_route
    assign ack_out[i]  = ack_hit  && (owner == MW'(i));
    assign done_out[i] = done_hit && (owner == MW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= MED_IDLE;
      owner  <= '0;
      target <= '0;
    end else begin
      unique case (phase)
        MED_IDLE: if (grant_any) begin
          phase  <= MED_WAIT;
          owner  <= grant_idx;
          target <= grant_sel;
        end
        MED_WAIT: if (ack_hit) phase <= MED_XFER;
        MED_XFER: if (done_hit) begin
          phase  <= MED_IDLE;
          owner  <= '0;
          target <= '0;
        end
        default: phase <= MED_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arb_shared_medium.sv
module arb_shared_medium
  import arb_pkg::*;
#(
  parameter int N = 2,
  parameter int M = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N-1:0]                           m_req,
  input  logic [N*((M > 1) ? $clog2(M) : 1)-1:0] m_sel,
  output logic [N-1:0]                           m_ack,
  output logic [N-1:0]                           m_done,
  output logic [M-1:0]                           s_req,
  input  logic [M-1:0]                           s_ack,
  input  logic [M-1:0]                           s_done
);

  localparam int SW = (M > 1) ? $clog2(M) : 1;
  localparam int MW = (N > 1) ? $clog2(N) : 1;

  // Named internal events, brought out for the checker.
  logic [N-1:0]    pend;
  logic [N*SW-1:0] pend_sel;
  logic [N-1:0]    owned;
  logic [N-1:0]    accept;
  logic [N-1:0]    grant_vec;
  logic [N-1:0]    cf_req;
  logic [N-1:0]    dly_req;
  logic            idle;
  logic            inflight;
  logic [MW-1:0]   owner;
  logic [MW-1:0]   grant_idx;
  logic [SW-1:0]   grant_sel;
  logic [31:0]     pick_w;

  assign inflight = !idle;

  for (genvar i = 0; i < N; i++) begin : g_own
    assign owned[i] = inflight && (owner == MW'(i));
  end

  assign accept    = m_req & ~pend & ~owned;
  assign pick_w    = lowest_set(32'(pend | accept));
  assign grant_vec = idle ? pick_w[N-1:0] : '0;
  assign cf_req    = grant_vec & accept;
  assign dly_req   = grant_vec & pend;

  always_comb begin
    grant_idx = '0;
    grant_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_vec[i]) begin
        grant_idx = MW'(i);
        grant_sel = pend[i] ? pend_sel[i*SW +: SW] : m_sel[i*SW +: SW];
      end
    end
  end

  always_comb begin
    s_req = '0;
    if (|grant_vec) s_req[grant_sel] = 1'b1;
  end

  arb_pending #(.N(N), .SW(SW)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .grant    (grant_vec),
    .sel_in   (m_sel),
    .pend     (pend),
    .pend_sel (pend_sel)
  );

  arb_medium_ctl #(.N(N), .M(M), .SW(SW), .MW(MW)) u_medium (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_any (|grant_vec),
    .grant_idx (grant_idx),
    .grant_sel (grant_sel),
    .s_ack     (s_ack),
    .s_done    (s_done),
    .idle      (idle),
    .owner     (owner),
    .ack_out   (m_ack),
    .done_out  (m_done)
  );

endmodule

// File: rtl/arb_shared_medium_chk.sv
module arb_shared_medium_chk #(
  parameter int N = 2,
  parameter int M = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [M-1:0] s_req,
  input logic [N-1:0] m_ack,
  input logic [N-1:0] m_done,
  input logic [N-1:0] grant_vec,
  input logic [N-1:0] dly_req,
  input logic [N-1:0] pend,
  input logic         inflight
);

  p_single_slave_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_req));

  p_single_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ack) && $onehot0(m_done));

  // R5: medium reserved from forwarding until done
  p_quiet_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> (s_req == '0));

  p_req_reserves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req != '0) |=> inflight);

  p_ack_needs_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack != '0) |-> inflight);

  p_done_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done != '0) |=> !inflight);

  p_delayed_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_req != '0) |-> ($countones(grant_vec) == 1 && $countones(s_req) == 1));

  for (genvar i = 0; i < N; i++) begin : g_pend
    p_reissue_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dly_req[i] |=> !pend[i]);
  end

endmodule

bind arb_shared_medium arb_shared_medium_chk #(.N(N), .M(M)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_req     (s_req),
  .m_ack     (m_ack),
  .m_done    (m_done),
  .grant_vec (grant_vec),
  .dly_req   (dly_req),
  .pend      (pend),
  .inflight  (inflight)
);

// File: tb/test_arb_shared_medium.sv
module test_arb_shared_medium;

  localparam int N  = 2;
  localparam int M  = 2;
  localparam int SW = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    m_req;
  logic [N*SW-1:0] m_sel;
  logic [M-1:0]    s_ack;
  logic [M-1:0]    s_done;
  wire  [N-1:0]    m_ack;
  wire  [N-1:0]    m_done;
  wire  [M-1:0]    s_req;

  int checks = 0;
  int fails  = 0;
  logic [M-1:0] exp_q[$];

  always #5 clk = ~clk;

  arb_shared_medium #(.N(N), .M(M)) i_arb_shared_medium (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_sel(m_sel),
    .m_ack(m_ack), .m_done(m_done), .s_req(s_req),
    .s_ack(s_ack), .s_done(s_done)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver side of the scoreboard: the target expected for the next forwarded request.
  task automatic expect_target(input int t);
    logic [M-1:0] v;
    v = '0;
    v[t] = 1'b1;
    exp_q.push_back(v);
  endtask

  // Monitor side: every forwarded request must match the next queued expectation.
  always @(negedge clk) begin
    #3;
    if (rst_n && s_req !== '0) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected forward actual=%0h expected=0", s_req);
      end else begin
        logic [M-1:0] e;
        e = exp_q.pop_front();
        if (s_req !== e) begin
          fails++;
          $display("FAIL R4 forward order actual=%0h expected=%0h", s_req, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_req = '0; m_sel = '0; s_ack = '0; s_done = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset s_req", 8'(s_req), 8'h0);
    chk("R1 reset m_ack", 8'(m_ack), 8'h0);
    chk("R1 reset m_done", 8'(m_done), 8'h0);
    @(negedge clk); rst_n = 1'b1;
    #2 chk("R1 idle after reset", 8'(s_req), 8'h0);

    // Single request, target 1
    @(negedge clk); m_req = 2'b01; m_sel = 2'b01; expect_target(1);
    #2 chk("R2 lone forward", 8'(s_req), 8'h2);
    @(negedge clk); m_req = '0; s_ack = 2'b01;
    #2 chk("R5 no forward in flight", 8'(s_req), 8'h0);
    chk("R6 wrong target ack ignored", 8'(m_ack), 8'h0);
    @(negedge clk); s_ack = 2'b10;
    #2 chk("R6 ack routed", 8'(m_ack), 8'h1);
    chk("R7 no early done", 8'(m_done), 8'h0);
    @(negedge clk); s_ack = '0; s_done = 2'b01;
    #2 chk("R7 wrong target done ignored", 8'(m_done), 8'h0);
    @(negedge clk); s_done = 2'b10;
    #2 chk("R7 done routed", 8'(m_done), 8'h1);
    @(negedge clk); s_done = '0;
    #2 chk("R7 idle afterwards", 8'(s_req), 8'h0);

    // Collision: initiator 0 to target 0, initiator 1 to target 1
    @(negedge clk); m_req = 2'b11; m_sel = 2'b10; expect_target(0);
    #2 chk("R3 priority win", 8'(s_req), 8'h1);
    @(negedge clk); m_req = 2'b10; m_sel = 2'b00;
    #2 chk("R8 repeat while pending", 8'(s_req), 8'h0);
    @(negedge clk); m_req = '0; s_ack = 2'b01;
    #2 chk("R6 ack to winner", 8'(m_ack), 8'h1);
    @(negedge clk); s_ack = '0; s_done = 2'b01;
    #2 chk("R7 done to winner", 8'(m_done), 8'h1);
    @(negedge clk); s_done = '0; expect_target(1);
    #2 chk("R4 delayed reissue keeps target", 8'(s_req), 8'h2);
    @(negedge clk); s_ack = 2'b10; m_req = 2'b10;
    #2 chk("R6 ack to delayed owner", 8'(m_ack), 8'h2);
    @(negedge clk); s_ack = '0; m_req = 2'b01; m_sel = 2'b01;
    #2 chk("R5 held while busy", 8'(s_req), 8'h0);
    @(negedge clk); m_req = '0; s_done = 2'b10;
    #2 chk("R7 done to delayed owner", 8'(m_done), 8'h2);
    @(negedge clk); s_done = '0; expect_target(1);
    #2 chk("R4 busy-time request reissued", 8'(s_req), 8'h2);
    @(negedge clk); s_ack = 2'b10;
    #2 chk("R6 ack to initiator 0", 8'(m_ack), 8'h1);
    @(negedge clk); s_ack = '0; s_done = 2'b10;
    #2 chk("R7 done to initiator 0", 8'(m_done), 8'h1);
    @(negedge clk); s_done = '0;
    #2 chk("R8 owner repeat dropped", 8'(s_req), 8'h0);

    // Fresh higher-priority request beats an older pending one
    @(negedge clk); m_req = 2'b01; m_sel = 2'b10; expect_target(0);
    #2 chk("R2 forward target 0", 8'(s_req), 8'h1);
    @(negedge clk); m_req = 2'b10;
    #2 chk("R5 loser waits", 8'(s_req), 8'h0);
    @(negedge clk); m_req = '0; s_ack = 2'b01;
    #2 chk("R6 ack", 8'(m_ack), 8'h1);
    @(negedge clk); s_ack = '0; s_done = 2'b01;
    #2 chk("R7 done", 8'(m_done), 8'h1);
    @(negedge clk); s_done = '0; m_req = 2'b01; expect_target(0);
    #2 chk("R4 fresh higher wins over pending", 8'(s_req), 8'h1);
    @(negedge clk); m_req = '0; s_ack = 2'b01;
    #2 chk("R6 ack", 8'(m_ack), 8'h1);
    @(negedge clk); s_ack = '0; s_done = 2'b01;
    #2 chk("R7 done", 8'(m_done), 8'h1);
    @(negedge clk); s_done = '0; expect_target(1);
    #2 chk("R4 pending served last", 8'(s_req), 8'h2);
    @(negedge clk); s_ack = 2'b10;
    #2 chk("R6 ack", 8'(m_ack), 8'h2);
    @(negedge clk); s_ack = '0; s_done = 2'b10;
    #2 chk("R7 done", 8'(m_done), 8'h2);
    @(negedge clk); s_done = '0;
    #2 chk("R9 medium quiet", 8'(s_req), 8'h0);

    @(negedge clk);
    chk("R9 all expected forwards seen", 8'(exp_q.size()), 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule